// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

An eight-stage (by default) register that takes a parallel word into its stages and then moves it out one bit per shift through its last stage. Every input is sampled by a free-running system clock. A shift is requested by a rising edge on the logical OR of two sampled inputs, `shift_ck` and `ck_hold`. Either input can serve as the shift clock while the other is held low. While either one stays high, no further rising edge on the combined signal can occur, so the register holds.

A small state machine, `psr_edge_fsm`, tracks the last sampled level of the combined signal. It has two states. `CK_LOW` means the last sample was 0, and `CK_HIGH` means it was 1. The transition `CK_LOW -> CK_HIGH` is taken when the combined signal is sampled high; while in `CK_LOW`, that sample also raises the one-cycle `rise` strobe. The transition `CK_HIGH -> CK_LOW` is taken when the combined signal is sampled low. Otherwise the machine stays in its state. Reset forces `CK_LOW`.

A decoder turns `load_n` and `rise` into one of three operations: `OP_LOAD`, `OP_SHIFT` or `OP_HOLD`. The stage chain carries out that operation. The last stage is driven out in true and complemented form, and all stages are visible for debugging. Several blocks can be chained by feeding one block's `tap_out` into the next block's `serial_in`.

Top module: `psr_shift_reg`

## Requirements
- R1: With `load_n` low at a system-clock edge, every stage takes its parallel input at that edge (`stage_q[i]` takes `par_d[i]`; bit 0 is the first stage). The values of `shift_ck`, `ck_hold` and `serial_in` make no difference.
- R2: A load has priority over a rising edge of the combined clock that is detected in the same cycle.
- R3: With `load_n` high and `ck_hold` high, and the combined clock already sampled high in the previous cycle, all stages keep their values while `shift_ck` toggles.
- R4: With `load_n` high, a cycle in which `shift_ck | ck_hold` is sampled 1 after a 0 shifts the register at that same edge. Stage 0 takes `serial_in`, and stage i takes the old value of stage i-1.
- R5: With `load_n` high and no rising edge of the combined clock (it is steady or falling), all stages hold.
- R6: With `shift_ck` low, a rising `ck_hold` acts as the shift clock and shifts exactly as in R4.
- R7: `tap_out` equals the last stage, and `tap_out_n` is its complement, at all times.
- R8: A synchronous active-high `rst` clears all stages to 0, so `tap_out_n` reads 1. It also clears the edge history: a combined clock that is already high in the first cycle after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_ck | input | 1 | Sampled shift clock |
| ck_hold | input | 1 | Sampled clock inhibit, ORed with `shift_ck` |
| load_n | input | 1 | Active-low parallel load |
| serial_in | input | 1 | Bit entering stage 0 on a shift |
| par_d | input | WIDTH | Parallel data, bit i to stage i |
| tap_out | output | 1 | Last stage |
| tap_out_n | output | 1 | Complement of the last stage |
| stage_q | output | WIDTH | All stage values, for debugging |

## Verification
Every result is due at the first system-clock edge after the inputs that cause it: a load, a shift or a hold takes effect at the edge that samples `load_n` and the combined clock. The tap outputs follow the stages with no further delay. The bench applies inputs at a falling edge and updates its queue model for the coming rising edge. It then compares stages and taps at the next falling edge, exactly one register stage later. Each comparison carries the label of the operation the model applied in that cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Last sampled level of the combined shift clock
    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_e;

    // Operation applied to the stage chain at the next edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } psr_op_e;

endpackage

// File: rtl/psr_edge_fsm.sv
module psr_edge_fsm
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_ck,
    input  logic ck_hold,
    output logic rise
);

    ck_state_e state_q;
    ck_state_e state_d;
    logic      comb_ck;

    assign comb_ck = shift_ck | ck_hold;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            CK_LOW: begin
                if (comb_ck) begin
                    state_d = CK_HIGH;
                    rise    = 1'b1;
                end
            end
            CK_HIGH: begin
                if (!comb_ck) begin
                    state_d = CK_LOW;
                end
            end
            default: begin
                state_d = CK_LOW;
            end
        endcase
    end

endmodule

// File: rtl/psr_op_decode.sv
module psr_op_decode
    import psr_pkg::*;
(
    input  logic    load_n,
    input  logic    rise,
    output psr_op_e op
);

    // Load wins over a coincident shift request
    always_comb begin
        unique case ({load_n, rise})
            2'b00, 2'b01: op = OP_LOAD;
            2'b11:        op = OP_SHIFT;
            default:      op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/psr_stage_chain.sv
module psr_stage_chain
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  psr_op_e          op,
    input  logic             serial_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] stage_q
);

    logic [WIDTH-1:0] feed;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                assign feed[gi] = serial_in;
            end else begin : g_body
                assign feed[gi] = stage_q[gi-1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[gi] <= 1'b0;
                end else begin
                    unique case (op)
                        OP_LOAD:  stage_q[gi] <= par_d[gi];
                        OP_SHIFT: stage_q[gi] <= feed[gi];
                        default:  stage_q[gi] <= stage_q[gi];
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/psr_shift_reg.sv
module psr_shift_reg
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_ck,
    input  logic             ck_hold,
    input  logic             load_n,
    input  logic             serial_in,
    input  logic [WIDTH-1:0] par_d,
    output logic             tap_out,
    output logic             tap_out_n,
    output logic [WIDTH-1:0] stage_q
);

    localparam int LAST = WIDTH - 1;

    logic    rise;
    psr_op_e op;

    psr_edge_fsm u_edge (
        .clk      (clk),
        .rst      (rst),
        .shift_ck (shift_ck),
        .ck_hold  (ck_hold),
        .rise     (rise)
    );

    psr_op_decode u_dec (
        .load_n (load_n),
        .rise   (rise),
        .op     (op)
    );

    psr_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .serial_in (serial_in),
        .par_d     (par_d),
        .stage_q   (stage_q)
    );

    assign tap_out   = stage_q[LAST];
    assign tap_out_n = ~stage_q[LAST];

endmodule

// File: rtl/psr_shift_reg_chk.sv
module psr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_ck,
    input logic             ck_hold,
    input logic             load_n,
    input logic             serial_in,
    input logic [WIDTH-1:0] par_d,
    input logic             tap_out,
    input logic             tap_out_n,
    input logic [WIDTH-1:0] stage_q
);

    // Independent record of the previous combined clock sample
    logic or_q;
    logic cur_or;
    logic edge_up;

    assign cur_or  = shift_ck | ck_hold;
    assign edge_up = cur_or & ~or_q;

    always_ff @(posedge clk) begin
        if (rst) or_q <= 1'b0;
        else     or_q <= cur_or;
    end

    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stage_q == $past(par_d));

    p_load_prio_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_n && edge_up) |=> stage_q == $past(par_d));

    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (load_n && ck_hold && or_q) |=> $stable(stage_q));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (load_n && edge_up) |=>
            stage_q == {$past(stage_q[WIDTH-2:0]), $past(serial_in)});

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && !edge_up) |=> $stable(stage_q));

    p_inh_clock_r6: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_ck && ck_hold && !or_q) |=>
            stage_q == {$past(stage_q[WIDTH-2:0]), $past(serial_in)});

    p_tap_r7: assert property (@(posedge clk) disable iff (rst)
        (tap_out == stage_q[WIDTH-1]) && (tap_out_n != tap_out));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (stage_q == '0) && tap_out_n);

endmodule

bind psr_shift_reg psr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_ck  (shift_ck),
    .ck_hold   (ck_hold),
    .load_n    (load_n),
    .serial_in (serial_in),
    .par_d     (par_d),
    .tap_out   (tap_out),
    .tap_out_n (tap_out_n),
    .stage_q   (stage_q)
);

// File: tb/psr_shift_reg_test.sv
module psr_shift_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_ck = 1'b0;
    logic         ck_hold = 1'b0;
    logic         load_n = 1'b1;
    logic         serial_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic         tap_out;
    logic         tap_out_n;
    logic [W-1:0] stage_q;

    always #2.5 clk = ~clk;

    psr_shift_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .shift_ck(shift_ck), .ck_hold(ck_hold),
        .load_n(load_n), .serial_in(serial_in), .par_d(par_d),
        .tap_out(tap_out), .tap_out_n(tap_out_n), .stage_q(stage_q)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit mq[$];      // model stages, mq[0] is the first stage
    bit m_or = 0;   // model of the last combined clock sample

    function automatic logic [W-1:0] model_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = mq[i];
        return v;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_taps();
        check("R7 tap", W'(tap_out), W'(mq[W-1]));
        check("R7 tap_n", W'(tap_out_n), W'(!mq[W-1]));
    endtask

    // One reset cycle
    task automatic rcyc(bit sck, bit hld);
        rst = 1'b1; shift_ck = sck; ck_hold = hld; load_n = 1'b1;
        for (int i = 0; i < W; i++) mq[i] = 1'b0;
        m_or = 1'b0;
        @(negedge clk);
        check("R8 reset", stage_q, '0);
        check("R8 tap_n", W'(tap_out_n), W'(1));
    endtask

    // One operating cycle: drive, advance the model, compare one edge later
    task automatic cyc(bit ld_n, bit sck, bit hld, bit sin, logic [W-1:0] pd);
        string tag;
        bit    cur;
        bit    rise;
        rst = 1'b0; load_n = ld_n; shift_ck = sck; ck_hold = hld;
        serial_in = sin; par_d = pd;
        cur  = sck | hld;
        rise = cur && !m_or;
        if (!ld_n) begin
            tag = rise ? "R2 load-priority" : "R1 load";
            for (int i = 0; i < W; i++) mq[i] = pd[i];
        end else if (rise) begin
            tag = sck ? "R4 shift" : "R6 inhibit-as-clock";
            mq.push_front(sin);
            void'(mq.pop_back());
        end else begin
            tag = hld ? "R3 inhibit-hold" : "R5 idle-hold";
        end
        m_or = cur;
        @(negedge clk);
        check(tag, stage_q, model_vec());
        check_taps();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        for (int i = 0; i < W; i++) mq.push_back(1'b0);
        @(negedge clk);
        // R8: reset with the combined clock already high
        repeat (3) rcyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, '0);
        check("R8 history-cleared", stage_q, W'(1));

        for (int b = 0; b < 6; b++) begin
            word = W'($urandom);
            // R1: load with noisy clock, inhibit and serial input
            cyc(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), word);
            cyc(1'b0, 1'b0, 1'b0, 1'($urandom), word);
            // R4: eight shifts
            for (int k = 0; k < W; k++) begin
                cyc(1'b1, 1'b0, 1'b0, 1'($urandom), W'($urandom));
                cyc(1'b1, 1'b1, 1'b0, 1'($urandom), W'($urandom));
            end
            // R3: inhibit raised while clock high, clock toggles
            cyc(1'b1, 1'b1, 1'b1, 1'($urandom), W'($urandom));
            for (int k = 0; k < 4; k++) begin
                cyc(1'b1, 1'b0, 1'b1, 1'($urandom), W'($urandom));
                cyc(1'b1, 1'b1, 1'b1, 1'($urandom), W'($urandom));
            end
            // R5: clock steady high, then falling, then steady low
            cyc(1'b1, 1'b1, 1'b0, 1'($urandom), W'($urandom));
            cyc(1'b1, 1'b1, 1'b0, 1'($urandom), W'($urandom));
            cyc(1'b1, 1'b0, 1'b0, 1'($urandom), W'($urandom));
            cyc(1'b1, 1'b0, 1'b0, 1'($urandom), W'($urandom));
            // R6: inhibit used as the clock
            for (int k = 0; k < 3; k++) begin
                cyc(1'b1, 1'b0, 1'b1, 1'($urandom), W'($urandom));
                cyc(1'b1, 1'b0, 1'b0, 1'($urandom), W'($urandom));
            end
            // R2: load coincides with a rising clock
            word = W'($urandom);
            cyc(1'b0, 1'b1, 1'b0, 1'($urandom), word);
            check("R2 loaded word", stage_q, word);
            cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
        end

        // R8: reset in the middle of operation
        rcyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, '0);
        check("R8 history after mid reset", stage_q, W'(1));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule